// File: doc/BRIEF.md
# Prescaled 16-bit Timer/Counter

This block is a 16-bit up-counter that sits on an 8-bit register bus. Its count source is either an internal instruction-rate tick (the system clock divided by four) or rising edges seen on an external clock pin. The selected source passes through a power-of-two prescaler (divide by 1, 2, 4 or 8) before it reaches the counter. The external path can go through a two-flop synchronizer, or it can bypass that synchronizer. Without the synchronizer the pin is still sampled by one flop in the system clock domain, so the edge arrives earlier.

An enable bit gates counting. A compare-match trigger input clears all sixteen bits synchronously. A wrap from 0xFFFF to 0x0000 sets a sticky overflow flag, which is also driven out as an interrupt line. A wide-access mode lets software read and write all sixteen bits atomically through a buffered high byte. Reading the low byte captures the live high byte into the buffer. Writing the low byte loads the buffered high byte and the written low byte into the counter in the same edge.

Top module: `tmr16_top`

## Requirements
- R1: After reset the control register reads 0x00, both count bytes read 0x00, and `irq_flag` is low.
- R2: Control register (address 0) fields are: bit 0 run, bit 1 external source, bit 2 bypass synchronizer, bits 4:3 prescale select, bit 5 wide access, bit 6 spare (stored and read back), bit 7 overflow flag. With run=1, internal source and prescale 00, the count advances once every 4 clocks, and the first increment lands on the 4th rising edge after the edge that wrote the control register. The count never changes by anything other than +1 unless it is written or cleared.
- R3: Prescale select value s divides the selected tick stream by 2^s (00→1, 01→2, 10→4, 11→8). With the internal source, the first increment after a control write lands on edge 4·2^s.
- R4: With bit 1 set, the count advances once per rising edge of `ext_clk`. Falling edges and a held high level do not advance it.
- R5: With bit 2 = 1 (bypass), an `ext_clk` rise first sampled at edge A shows up in the count at edge A+1. With bit 2 = 0 (synchronized), it shows up at edge A+3.
- R6: With run=0, the count holds its value.
- R7: A high `trig_clr` at a clock edge clears the whole count. A write to a count byte in the same cycle takes priority over the clear.
- R8: A wrap from 0xFFFF to 0x0000 sets the flag (read at control bit 7, driven on `irq_flag`). A control write with bit 7 = 0 clears the flag, and a control write with bit 7 = 1 leaves it as it was.
- R9: In wide mode (bit 5 = 1): a read of the low byte (address 1, `bus_rd` high) copies the live high byte into a buffer; a read of address 2 returns the buffer; a write to address 2 loads only the buffer; a write to address 1 loads {buffer, data} into the count.
- R10: In normal mode, address 1 is the live low byte and address 2 is the live high byte, and each byte is written directly. Address 3 reads 0x00.
- R11: A control write or a count write restarts the prescaler and the instruction divider, so the next increment is a full period away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 control, 1 low byte, 2 high byte |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effect in wide mode) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| ext_clk | input | 1 | External count clock pin |
| trig_clr | input | 1 | Compare-match clear trigger |
| irq_flag | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with its defaults: an 8-bit bus, a divide-by-four instruction tick, a 2-bit prescale field and a two-stage synchronizer. These values keep every prescale ratio small enough that exact increment edges are easy to predict. The wrap from 0xFFFF can be reached in eight clocks after the count is preloaded, and the one-flop and three-flop external latencies can be told apart at single-edge resolution.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int PS_W     = 2;
  localparam int FLAG_BIT = 7;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_LO   = 2'd1,
    REG_HI   = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic            spare;
    logic            wide;
    logic [PS_W-1:0] ps_sel;
    logic            no_sync;
    logic            ext_sel;
    logic            run;
  } ctrl_t;
endpackage

// File: rtl/tmr16_inst_div.sv
module tmr16_inst_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] div_q, div_d;

  assign tick = (div_q == LAST);

  always_comb begin
    div_d = div_q;
    if (restart)   div_d = '0;
    else if (tick) div_d = '0;
    else           div_d = div_q + DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/tmr16_prescaler.sv
module tmr16_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             src_tick,
  input  logic [SEL_W-1:0] sel,
  output logic             out_tick
);
  localparam int CW = (1 << SEL_W) - 1;

  logic [CW-1:0] pc_q, pc_d, term;

  // terminal count 2^sel - 1 as a thermometer mask
  always_comb begin
    for (int i = 0; i < CW; i++) term[i] = (i < int'(sel));
  end

  assign out_tick = src_tick & (pc_q == term);

  always_comb begin
    pc_d = pc_q;
    if (restart)       pc_d = '0;
    else if (src_tick) pc_d = out_tick ? '0 : pc_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/tmr16_edge_front.sv
module tmr16_edge_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic bypass,
  output logic rise
);
  logic [STAGES:0] chain_q, chain_d;
  logic            synced, cur, prev_q;

  generate
    if (STAGES == 0) begin : g_nosync
      assign chain_d = pin;
      assign synced  = chain_q[0];
    end else begin : g_sync
      assign chain_d = {chain_q[STAGES-1:0], pin};
      assign synced  = chain_q[STAGES];
    end
  endgenerate

  assign cur  = bypass ? chain_q[0] : synced;
  assign rise = cur & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= cur;
    end
  end
endmodule

// File: rtl/tmr16_regs.sv
module tmr16_regs
  import tmr16_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  input  logic               cnt_inc,
  input  logic               trig_clr,
  output ctrl_t              ctrl,
  output logic               restart,
  output logic [2*BUS_W-1:0] count,
  output logic               ovf_flag
);
  localparam int CNT_W = 2 * BUS_W;
  localparam int CTL_W = $bits(ctrl_t);

  reg_sel_e         asel;
  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BUS_W-1:0] hbuf_q, hbuf_d;
  logic             flag_q, flag_d;
  logic             wr_ctrl, wr_lo, wr_hi, rd_lo, cnt_wr, wrap;

  assign asel    = reg_sel_e'(bus_addr);
  assign wr_ctrl = bus_wr && (asel == REG_CTRL);
  assign wr_lo   = bus_wr && (asel == REG_LO);
  assign wr_hi   = bus_wr && (asel == REG_HI);
  assign rd_lo   = bus_rd && (asel == REG_LO);

  // counter next state: bus write > trigger clear > increment
  always_comb begin
    cnt_d  = cnt_q;
    cnt_wr = 1'b0;
    wrap   = 1'b0;
    if (wr_lo) begin
      cnt_wr = 1'b1;
      cnt_d  = {(ctrl_q.wide ? hbuf_q : cnt_q[CNT_W-1:BUS_W]), bus_wdata};
    end else if (wr_hi && !ctrl_q.wide) begin
      cnt_wr = 1'b1;
      cnt_d  = {bus_wdata, cnt_q[BUS_W-1:0]};
    end else if (trig_clr) begin
      cnt_d = '0;
    end else if (cnt_inc) begin
      cnt_d = cnt_q + CNT_W'(1);
      wrap  = &cnt_q;
    end
  end

  always_comb begin
    hbuf_d = hbuf_q;
    if (ctrl_q.wide) begin
      if (wr_hi)      hbuf_d = bus_wdata;
      else if (rd_lo) hbuf_d = cnt_q[CNT_W-1:BUS_W];
    end
  end

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = ctrl_t'(bus_wdata[CTL_W-1:0]);
  end

  // set dominates the software clear
  always_comb begin
    flag_d = flag_q;
    if (wrap)         flag_d = 1'b1;
    else if (wr_ctrl) flag_d = flag_q & bus_wdata[FLAG_BIT];
  end

  always_comb begin
    bus_rdata = '0;
    unique case (asel)
      REG_CTRL: begin
        bus_rdata[CTL_W-1:0]  = ctrl_q;
        bus_rdata[FLAG_BIT]   = flag_q;
      end
      REG_LO:   bus_rdata = cnt_q[BUS_W-1:0];
      REG_HI:   bus_rdata = ctrl_q.wide ? hbuf_q : cnt_q[CNT_W-1:BUS_W];
      default:  bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
      hbuf_q <= '0;
      flag_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      cnt_q  <= cnt_d;
      hbuf_q <= hbuf_d;
      flag_q <= flag_d;
    end
  end

  assign ctrl     = ctrl_q;
  assign count    = cnt_q;
  assign ovf_flag = flag_q;
  assign restart  = wr_ctrl | cnt_wr;
endmodule

// File: rtl/tmr16_top.sv
module tmr16_top
  import tmr16_pkg::*;
#(
  parameter int BUS_W       = 8,
  parameter int INST_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             ext_clk,
  input  logic             trig_clr,
  output logic             irq_flag
);
  localparam int CNT_W = 2 * BUS_W;

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  ctrl_t            ctrl_w;
  logic             restart_w, inst_tick, ext_rise, src_tick, cnt_inc, run_w;
  logic [CNT_W-1:0] count_w;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  tmr16_inst_div #(.DIV(INST_DIV)) u_div (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .restart (restart_w),
    .tick    (inst_tick)
  );

  tmr16_edge_front #(.STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .pin    (ext_clk),
    .bypass (ctrl_w.no_sync),
    .rise   (ext_rise)
  );

  assign run_w    = ctrl_w.run;
  assign src_tick = run_w & (ctrl_w.ext_sel ? ext_rise : inst_tick);

  tmr16_prescaler #(.SEL_W(PS_W)) u_psc (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .restart  (restart_w),
    .src_tick (src_tick),
    .sel      (ctrl_w.ps_sel),
    .out_tick (cnt_inc)
  );

  tmr16_regs #(.BUS_W(BUS_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cnt_inc   (cnt_inc),
    .trig_clr  (trig_clr),
    .ctrl      (ctrl_w),
    .restart   (restart_w),
    .count     (count_w),
    .ovf_flag  (irq_flag)
  );
endmodule

// File: rtl/tmr16_checker.sv
module tmr16_checker #(
  parameter int BUS_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         bus_addr,
  input logic               bus_wr,
  input logic [BUS_W-1:0]   bus_wdata,
  input logic               trig_clr,
  input logic               run,
  input logic [2*BUS_W-1:0] count,
  input logic               flag
);
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && !trig_clr) |=> (count == $past(count) || count == $past(count) + 1'b1));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !bus_wr && !trig_clr) |=> $stable(count));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_clr && !bus_wr) |=> (count == '0));

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> ($past(count) == '1 && count == '0));

  assert_flag_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(bus_wr && bus_addr == 2'd0)) |=> flag);

  assert_lo_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1) |=> (count[BUS_W-1:0] == $past(bus_wdata)));
endmodule

bind tmr16_top tmr16_checker #(.BUS_W(BUS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .trig_clr  (trig_clr),
  .run       (run_w),
  .count     (count_w),
  .flag      (irq_flag)
);

// File: tb/tmr16_top_test.sv
`timescale 1ns/100ps
module tmr16_top_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic       bus_wr, bus_rd, ext_clk, trig_clr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       irq_flag;
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         done  = 1'b0;

  always #2 clk = ~clk;

  tmr16_top uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_clk(ext_clk), .trig_clr(trig_clr), .irq_flag(irq_flag)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a;
    #0.5;
    v = bus_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd_lo(output logic [7:0] v);
    @(negedge clk);
    bus_addr = 2'd1; bus_rd = 1'b1;
    #0.5 v = bus_rdata;
    @(posedge clk);
    #1 bus_rd = 1'b0;
  endtask

  task automatic zero_count();
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    peek(2'd0, v); chk("R1 ctrl", v, 8'h00);
    peek(2'd1, v); chk("R1 low", v, 8'h00);
    peek(2'd2, v); chk("R1 high", v, 8'h00);
    chk("R1 irq", {7'd0, irq_flag}, 8'h00);
    peek(2'd3, v); chk("R10 addr3", v, 8'h00);
  endtask

  task automatic t_internal();
    logic [7:0] v;
    zero_count();
    wr(2'd0, 8'h01);
    step(3); peek(2'd1, v); chk("R2 before 4th edge", v, 8'h00);
    step(1); peek(2'd1, v); chk("R2 at 4th edge", v, 8'h01);
    step(8); peek(2'd1, v); chk("R2 at 12th edge", v, 8'h03);
  endtask

  task automatic t_prescale();
    logic [7:0] v;
    for (int s = 1; s < 4; s++) begin
      zero_count();
      wr(2'd0, 8'h01 | 8'(s << 3));
      step(4 * (1 << s) * 2 - 1); peek(2'd1, v); chk("R3 edge before 2nd inc", v, 8'h01);
      step(1);                    peek(2'd1, v); chk("R3 2nd inc", v, 8'h02);
    end
  endtask

  task automatic t_hold();
    logic [7:0] v0, v1;
    wr(2'd0, 8'h00);
    peek(2'd1, v0);
    step(40);
    peek(2'd1, v1); chk("R6 hold while off", v1, v0);
  endtask

  task automatic t_restart();
    logic [7:0] v;
    zero_count();
    wr(2'd0, 8'h09);            // run, internal, divide by 2
    step(5);
    wr(2'd1, 8'h00);
    step(2); peek(2'd1, v); chk("R11 no inc at old slot", v, 8'h00);
    step(6); peek(2'd1, v); chk("R11 inc one period after write", v, 8'h01);
  endtask

  task automatic t_ext_latency(input logic [7:0] cfg, input int lat);
    logic [7:0] v;
    zero_count();
    wr(2'd0, cfg);
    @(negedge clk) ext_clk = 1'b1;
    step(lat); peek(2'd1, v); chk("R5 before latency", v, 8'h00);
    step(1);   peek(2'd1, v); chk("R5 at latency", v, 8'h01);
    step(4);   peek(2'd1, v); chk("R4 level held high", v, 8'h01);
    @(negedge clk) ext_clk = 1'b0;
    step(6);   peek(2'd1, v); chk("R4 falling edge ignored", v, 8'h01);
  endtask

  task automatic t_ext_count();
    logic [7:0] v;
    zero_count();
    wr(2'd0, 8'h17);            // run, external, bypass, divide by 4
    for (int i = 0; i < 9; i++) begin
      @(negedge clk) ext_clk = 1'b1;
      repeat (3) @(negedge clk);
      ext_clk = 1'b0;
      repeat (3) @(negedge clk);
    end
    step(6); peek(2'd1, v); chk("R4 9 edges / 4", v, 8'h02);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_overflow();
    logic [7:0] v;
    wr(2'd0, 8'h00);
    wr(2'd2, 8'hFF);
    wr(2'd1, 8'hFE);
    wr(2'd0, 8'h01);
    step(4); peek(2'd1, v); chk("R8 reach FFFF", v, 8'hFF);
    chk("R8 no flag yet", {7'd0, irq_flag}, 8'h00);
    step(4); peek(2'd1, v); chk("R8 wrap low", v, 8'h00);
    peek(2'd2, v); chk("R8 wrap high", v, 8'h00);
    peek(2'd0, v); chk("R8 flag bit", v, 8'h81);
    wr(2'd0, 8'h80);
    chk("R8 write 1 keeps", {7'd0, irq_flag}, 8'h01);
    wr(2'd0, 8'h00);
    chk("R8 write 0 clears", {7'd0, irq_flag}, 8'h00);
  endtask

  task automatic t_trigger();
    logic [7:0] v;
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h5A);
    wr(2'd1, 8'hA5);
    @(negedge clk) trig_clr = 1'b1;
    @(posedge clk); #1 trig_clr = 1'b0;
    peek(2'd1, v); chk("R7 clear low", v, 8'h00);
    peek(2'd2, v); chk("R7 clear high", v, 8'h00);
    wr(2'd2, 8'h33);
    @(negedge clk);
    trig_clr = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h44; bus_wr = 1'b1;
    @(posedge clk); #1 begin trig_clr = 1'b0; bus_wr = 1'b0; end
    peek(2'd1, v); chk("R7 write beats clear low", v, 8'h44);
    peek(2'd2, v); chk("R7 write beats clear high", v, 8'h33);
  endtask

  task automatic t_wide();
    logic [7:0] v;
    wr(2'd0, 8'h20);
    wr(2'd2, 8'h12);
    peek(2'd2, v); chk("R9 high reads buffer", v, 8'h12);
    wr(2'd0, 8'h00);
    peek(2'd2, v); chk("R9 buffer write leaves live high", v, 8'h33);
    wr(2'd0, 8'h20);
    wr(2'd1, 8'h34);
    wr(2'd0, 8'h00);
    peek(2'd2, v); chk("R9 atomic high", v, 8'h12);
    peek(2'd1, v); chk("R9 atomic low", v, 8'h34);
    wr(2'd0, 8'h20);
    wr(2'd2, 8'h77);
    rd_lo(v); chk("R9 low read value", v, 8'h34);
    @(negedge clk) trig_clr = 1'b1;
    @(posedge clk); #1 trig_clr = 1'b0;
    peek(2'd2, v); chk("R9 latched high survives clear", v, 8'h12);
    rd_lo(v);
    peek(2'd2, v); chk("R9 relatch high", v, 8'h00);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h9C);
    peek(2'd2, v); chk("R10 direct high", v, 8'h9C);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = 2'd0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_wdata = 8'h00; ext_clk = 1'b0; trig_clr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    step(3);
    t_reset();
    t_internal();
    t_prescale();
    t_hold();
    t_restart();
    t_ext_latency(8'h07, 1);    // bypass
    t_ext_latency(8'h03, 3);    // synchronized
    t_ext_count();
    t_overflow();
    t_trigger();
    t_wide();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule